// File: doc/BRIEF.md
# Four-Beat Burst Memory with Split Read and Write Ports

This block is an on-chip memory with one port that returns read data and a separate port that takes write data. Every command names one burst address, and each burst address owns four consecutive data words. A write command is followed by four data beats, one on each of the next four rising clock edges. Each beat is 18 bits wide and made of two 9-bit bytes, and each byte has its own active-low enable. A read command returns the four words of its burst on the read port, one word per cycle, with a valid flag.

Both command strobes are active low and are sampled, with the address, on the rising clock edge. A command of one kind is not accepted when the last accepted command was of the same kind. Traffic that alternates between reads and writes therefore runs at full rate. A command that arrives while the previous burst of the same kind is still moving is also refused. Reset clears the record of the last command.

Top module: `burst4_sram`

## Requirements
- R1: An edge where `rd_n` and `wr_n` are both high starts no operation, and it leaves the record of the last accepted command unchanged.
- R2: An accepted read of burst address A puts words {A,0}, {A,1}, {A,2}, {A,3} on `rdata`, with `rvalid` high. Word {A,0} appears in the cycle right after the accepting edge, and the other three follow in the next three cycles. Outside these four cycles `rvalid` is low.
- R3: A low on `rd_n` is ignored when the last accepted command was a read, even if deselect cycles came in between. It is also ignored while the previous read burst has more than its final beat still to present.
- R4: A write is accepted when `wr_n` is low and `rd_n` is high. When both are low, a read can start but a write never starts.
- R5: A low on `wr_n` is ignored when the last accepted command was a write, even if deselect cycles came in between. It is also ignored while the previous write burst is still collecting beats.
- R6: After a write is accepted at burst address A, the data on `wdata` at each of the next four rising edges is stored, in order, into words {A,0} through {A,3}.
- R7: `wbe_n` is sampled with each write beat. `wbe_n[0]` low stores `wdata[8:0]` and `wbe_n[1]` low stores `wdata[17:9]`. A high bit leaves that 9-bit byte of the word unchanged. Each byte of each beat is masked on its own.
- R8: While reset is asserted `rvalid` is low. Reset clears the record of the last command, so the first read or write after reset is accepted.
- R9: A read beat shows the array contents as they stand in the cycle it is presented. Write beats that have not yet been stored are not forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_n | input | 1 | Read command strobe, active low |
| wr_n | input | 1 | Write command strobe, active low |
| addr | input | AW | Burst address of the command |
| wdata | input | DW | Write data beat |
| wbe_n | input | DW/BW | Per-byte write enables, active low |
| rdata | output | DW | Read data beat |
| rvalid | output | 1 | High while a read beat is on `rdata` |

## Verification
The bench repeats a read after another read and a write after another write, both back to back and with deselect cycles in between. A design that tracked only the previous cycle would accept the second command, which shows up as extra read beats or as an overwritten burst. The bench issues a command with both strobes low after a write, and it would catch a design that let a write win or run both at once. A read is placed directly before a write to the same burst, and then directly after one. A design that forwarded write data, or read one cycle off, would return the wrong generation of data. The bench also sends a read command while a read burst is still streaming and resets the block with the last-command record set, which catches beat overlap and a record that survives reset.

// File: rtl/burst4_sram.sv
module burst4_sram #(
  parameter int AW = 5,
  parameter int DW = 18,
  parameter int BW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW/BW-1:0] wbe_n,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  localparam int NB    = DW / BW;
  localparam int DEPTH = 1 << (AW + 2);

  typedef enum logic [1:0] {K_NONE, K_RD, K_WR} kind_t;

  logic [DW-1:0] mem [DEPTH];
  kind_t         last_q;
  logic          rbusy, wbusy;
  logic [1:0]    rcnt, wcnt;
  logic [AW-1:0] raddr, waddr;

  wire rd_ready = !rbusy || (rcnt == 2'd3);
  wire wr_ready = !wbusy || (wcnt == 2'd3);
  wire rd_acc   = !rd_n && (last_q != K_RD) && rd_ready;
  wire wr_acc   = !wr_n && rd_n && (last_q != K_WR) && wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)      last_q <= K_NONE;
    else if (rd_acc) last_q <= K_RD;
    else if (wr_acc) last_q <= K_WR;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rbusy <= 1'b0;
      rcnt  <= '0;
      raddr <= '0;
    end else if (rd_acc) begin
      rbusy <= 1'b1;
      rcnt  <= '0;
      raddr <= addr;
    end else if (rbusy) begin
      rcnt <= rcnt + 2'd1;
      if (rcnt == 2'd3) rbusy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wbusy <= 1'b0;
      wcnt  <= '0;
      waddr <= '0;
    end else if (wr_acc) begin
      wbusy <= 1'b1;
      wcnt  <= '0;
      waddr <= addr;
    end else if (wbusy) begin
      wcnt <= wcnt + 2'd1;
      if (wcnt == 2'd3) wbusy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && wbusy) begin
      for (int b = 0; b < NB; b++) begin
        if (!wbe_n[b]) mem[{waddr, wcnt}][b*BW +: BW] <= wdata[b*BW +: BW];
      end
    end
  end

  assign rvalid = rbusy;
  assign rdata  = rbusy ? mem[{raddr, rcnt}] : '0;

  a_r3_no_read_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> !rd_acc);
  a_r5_no_write_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> !wr_acc);
  a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> (rvalid && rcnt == 2'd0));
  a_r2_beats_continue: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && rcnt != 2'd3) |=> rvalid);
  a_r1_deselect_keeps_record: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n && wr_n) |=> $stable(last_q));
  a_r6_write_beats_start: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> (wbusy && wcnt == 2'd0));
endmodule

// File: tb/tb_burst4_sram.sv
module tb_burst4_sram;
  localparam int AW = 5;
  localparam int DW = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_n = 1'b1, wr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [1:0] wbe_n = 2'b11;
  wire  [DW-1:0] rdata;
  wire  rvalid;

  always #10 clk = ~clk;

  burst4_sram #(.AW(AW), .DW(DW), .BW(9)) dut (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .wdata(wdata), .wbe_n(wbe_n), .rdata(rdata), .rvalid(rvalid));

  int checks = 0, errors = 0;
  string cur_req = "R8";
  logic [DW-1:0] expq[$];
  logic [DW-1:0] mdl [128];
  bit done = 0;

  function automatic logic [DW-1:0] wd(int a, int n, int s);
    return 18'(a * 1237 + n * 311 + s * 7919 + 5) ^ 18'h15A3C;
  endfunction

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] d, logic [1:0] be);
    logic [DW-1:0] r = old;
    if (!be[0]) r[8:0]  = d[8:0];
    if (!be[1]) r[17:9] = d[17:9];
    return r;
  endfunction

  task automatic step(bit r, bit w, int a, logic [DW-1:0] d, logic [1:0] be);
    rd_n = r; wr_n = w; addr = AW'(a); wdata = d; wbe_n = be;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) step(1, 1, 0, '0, 2'b11);
  endtask

  task automatic upd(int a, int s, logic [7:0] bes);
    for (int n = 0; n < 4; n++)
      mdl[{AW'(a), 2'(n)}] = merge(mdl[{AW'(a), 2'(n)}], wd(a, n, s), bes[2*n +: 2]);
  endtask

  task automatic push_read(int a);
    for (int n = 0; n < 4; n++) expq.push_back(mdl[{AW'(a), 2'(n)}]);
  endtask

  task automatic wr_beats(int a, int s, logic [7:0] bes, int first);
    for (int n = first; n < 4; n++) step(1, 1, 0, wd(a, n, s), bes[2*n +: 2]);
  endtask

  task automatic wr_burst(int a, int s, logic [7:0] bes);
    step(1, 0, a, '0, 2'b11);
    upd(a, s, bes);
    wr_beats(a, s, bes, 0);
  endtask

  task automatic rd_burst(int a);
    push_read(a);
    step(0, 1, a, '0, 2'b11);
    idle(4);
  endtask

  task automatic expect_quiet(int n);
    for (int i = 0; i < n; i++) begin
      step(1, 1, 0, '0, 2'b11);
      checks++;
      if (rvalid !== 1'b0) begin
        errors++;
        $display("FAIL %s rvalid actual=%b expected=0", cur_req, rvalid);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done && rvalid) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL %s unexpected read beat actual=%h expected=none", cur_req, rdata);
      end else begin
        logic [DW-1:0] e;
        e = expq.pop_front();
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s read beat actual=%h expected=%h", cur_req, rdata, e);
        end
      end
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    // R8: outputs idle in reset
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (rvalid !== 1'b0) begin
        errors++;
        $display("FAIL R8 rvalid in reset actual=%b expected=0", rvalid);
      end
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R6 / R2 / R4: fill every burst, read each back
    cur_req = "R6";
    for (int a = 0; a < 32; a++) begin
      wr_burst(a, 0, 8'h00);
      rd_burst(a);
    end

    // R7: per-beat, per-byte masking
    cur_req = "R7";
    wr_burst(4, 1, 8'hC6);
    rd_burst(4);

    // R3: read after read with deselects in between is ignored
    cur_req = "R3";
    step(0, 1, 4, '0, 2'b11);
    expect_quiet(5);

    // R1: deselects start nothing and keep the record
    cur_req = "R1";
    expect_quiet(3);

    // R5: write after write with deselects between is ignored
    cur_req = "R5";
    wr_burst(6, 2, 8'h00);
    idle(3);
    step(1, 0, 7, '0, 2'b11);
    wr_beats(7, 3, 8'h00, 0);
    rd_burst(7);

    // R5: write directly after write is ignored
    wr_burst(8, 4, 8'h00);
    idle(0);
    rd_n = 1; wr_n = 1;
    step(1, 0, 9, '0, 2'b11);
    upd(9, 50, 8'hFF);
    wr_beats(9, 5, 8'h00, 0);
    rd_burst(9);
    wr_burst(10, 5, 8'h00);
    rd_burst(8);

    // R4: both strobes low after a write gives a read, no write
    cur_req = "R4";
    wr_burst(11, 6, 8'h00);
    push_read(12);
    step(0, 0, 12, wd(12, 0, 7), 2'b00);
    for (int n = 1; n < 5; n++) step(1, 1, 0, wd(12, n, 7), 2'b00);
    wr_burst(13, 8, 8'h00);
    rd_burst(12);

    // R9: read then write on the same burst returns old data
    cur_req = "R9";
    wr_burst(14, 9, 8'h00);
    push_read(15);
    step(0, 1, 15, '0, 2'b11);
    step(1, 0, 15, '0, 2'b11);
    upd(15, 10, 8'h00);
    wr_beats(15, 10, 8'h00, 0);
    idle(2);
    rd_burst(15);

    // R9: write then read on the same burst returns new data
    step(1, 0, 16, '0, 2'b11);
    upd(16, 11, 8'h00);
    push_read(16);
    step(0, 1, 16, wd(16, 0, 11), 2'b00);
    wr_beats(16, 11, 8'h00, 1);
    idle(3);

    // R3: read while a read burst still streams is ignored
    cur_req = "R3";
    wr_burst(17, 12, 8'h00);
    push_read(18);
    step(0, 1, 18, '0, 2'b11);
    step(1, 0, 19, '0, 2'b11);
    upd(19, 13, 8'h00);
    step(0, 1, 20, wd(19, 0, 13), 2'b00);
    wr_beats(19, 13, 8'h00, 1);
    idle(3);
    cur_req = "R6";
    rd_burst(19);

    // R8: reset clears the last-command record (read case)
    cur_req = "R8";
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    checks++;
    if (rvalid !== 1'b0) begin
      errors++;
      $display("FAIL R8 rvalid after reset actual=%b expected=0", rvalid);
    end
    rd_burst(19);

    // R8: write case
    wr_burst(21, 14, 8'h00);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    wr_burst(22, 15, 8'h00);
    rd_burst(22);

    idle(6);
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL R2 missing read beats actual=%0d expected=0", expq.size());
    end
    done = 1;
    summary();
    $finish;
  end
endmodule